// File: doc/BRIEF.md
# Video Colour Tone Adjuster

This block sits in a pixel stream of 8-bit RGB video, with its vertical sync, horizontal sync and data-enable markers. It changes the picture's contrast, brightness, hue and saturation. Each pixel is first mapped to a luma/colour-difference space with the usual 16/128/128 offsets left out, so that every adjustment acts on values centred on zero. Luma is then scaled by a contrast gain and shifted by a brightness step. The two colour-difference components are rotated by a small hue angle and scaled by a saturation gain. Finally the pixel is mapped back to RGB, rounded, and clamped to 0..255.

The four control values are sampled in the same cycle as the pixel they act on. They may therefore change from one pixel to the next with no glitch. The three timing markers travel through a register chain of the same length as the pixel path, so they leave the block aligned with their pixel. The sine and cosine of the hue angle come from a table that the RTL builds from its parameters at elaboration time.

Top module: `vid_tone_adjust`

## Requirements
- R1: A pixel and its vsync/hsync/de markers presented in one cycle appear together at the outputs exactly 4 clock cycles later; the markers are delayed unchanged.
- R2: While `rst` is high at a clock edge, every output is 0 after that edge.
- R3: With contrast 128, brightness 0, hue 0 and saturation 128, each output channel equals the input channel within ±1.
- R4: A grey input (R = G = B) gives a grey output (R = G = B) for any setting of the four controls.
- R5: `contrast` is an unsigned gain with 7 fraction bits (code 128 = 1.0, code 255 ≈ 1.992). It multiplies the offset-free luma.
- R6: `brightness` is a 6-bit two's-complement value (−32..+31). It is added to the offset-free luma in units of one 8-bit luma step.
- R7: `hue` is 8-bit two's complement at 0.25 degree per code, so the angle is code/4 degrees. Codes above +120 act as +120 and codes below −120 act as −120 (±30°). The colour-difference pair is rotated as Cb·cosθ + Cr·sinθ and Cr·cosθ − Cb·sinθ.
- R8: `saturation` is an unsigned gain with 7 fraction bits (code 128 = 1.0) applied to both colour-difference components; code 0 yields a grey output.
- R9: Each output channel saturates to 0 when the converted value is negative and to 255 when it exceeds 255.
- R10: For any pixel and control setting, each output channel is within ±2 of a real-valued model. The model is: the forward matrix (Y' = 0.2568R + 0.5041G + 0.0979B, Cb' = −0.1482R − 0.2910G + 0.4392B, Cr' = 0.4392R − 0.3678G − 0.0714B), then the adjustments of R5–R8, then the inverse matrix (R = 1.1644Y' + 1.5960Cr', G = 1.1644Y' − 0.3918Cb' − 0.8130Cr', B = 1.1644Y' + 2.0172Cb'), then rounding and the clamp of R9.
- R11: Control values apply to the pixel sampled in the same cycle, even when they change on every pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| in_r | input | 8 | Red component in |
| in_g | input | 8 | Green component in |
| in_b | input | 8 | Blue component in |
| in_vs | input | 1 | Vertical sync in |
| in_hs | input | 1 | Horizontal sync in |
| in_de | input | 1 | Data enable in |
| contrast | input | 8 | Luma gain, 1.7 unsigned fixed point |
| brightness | input | 6 | Luma offset, two's complement |
| hue | input | 8 | Hue angle, two's complement, 0.25 degree per code |
| saturation | input | 8 | Colour-difference gain, 1.7 unsigned fixed point |
| out_r | output | 8 | Red component out |
| out_g | output | 8 | Green component out |
| out_b | output | 8 | Blue component out |
| out_vs | output | 1 | Vertical sync out |
| out_hs | output | 1 | Horizontal sync out |
| out_de | output | 1 | Data enable out |

## Verification
The bench streams a pixel every cycle and sweeps each control through all of its codes on coloured and grey pixels. The sweeps hit the hue codes past ±120, where a missing angle clamp would wrap the rotation the wrong way. They also hit saturation 0 and grey input, where a coefficient set whose rows do not sum to zero would leak a colour cast. A neutral-setting sweep over a 16-step RGB grid catches truncation in place of rounding, or too few fraction bits, which would drift past ±1. Large gains and extreme brightness drive the converted values past 0 and 255, so a missing clamp shows up as wrapped codes. A stream with different controls on every pixel catches controls that are misaligned by a stage.

// File: rtl/vta_pkg.sv
package vta_pkg;
    localparam int PIX_W    = 8;
    localparam int PIX_MAX  = (1 << PIX_W) - 1;
    localparam int FRAC_W   = 4;    // fraction bits carried on luma/chroma path
    localparam int COMP_W   = 16;
    localparam int COEF_F   = 12;   // fraction bits of matrix coefficients
    localparam int TRIG_F   = 14;   // fraction bits of sine/cosine
    localparam int GAIN_W   = 8;
    localparam int GAIN_F   = 7;
    localparam int BRI_W    = 6;
    localparam int HUE_W    = 8;
    localparam int HUE_LIM  = 120;  // 120 codes of 0.25 degree = 30 degrees
    localparam int ACC_W    = 40;
    localparam int PIPE_LAT = 4;

    typedef logic signed [COMP_W-1:0] comp_t;
    typedef logic signed [COMP_W-1:0] trig_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        logic [PIX_W-1:0] r;
        logic [PIX_W-1:0] g;
        logic [PIX_W-1:0] b;
    } rgb_t;

    typedef struct packed {
        comp_t y;
        comp_t cb;
        comp_t cr;
    } ycc_t;

    typedef struct packed {
        logic vs;
        logic hs;
        logic de;
    } sync_t;

    typedef struct packed {
        logic [GAIN_W-1:0] contrast;
        logic [BRI_W-1:0]  bright;
        logic [GAIN_W-1:0] sat;
    } ctl_t;

    // Forward matrix in Q12; each chroma row sums to zero so grey maps to zero chroma.
    localparam int KF_YR = 1052;
    localparam int KF_YG = 2065;
    localparam int KF_YB = 401;
    localparam int KF_UR = -607;
    localparam int KF_UG = -1192;
    localparam int KF_UB = 1799;
    localparam int KF_VR = 1799;
    localparam int KF_VG = -1506;
    localparam int KF_VB = -293;
    // Inverse matrix in Q12.
    localparam int KI_Y  = 4769;
    localparam int KI_RV = 6537;
    localparam int KI_GU = -1605;
    localparam int KI_GV = -3330;
    localparam int KI_BU = 8263;

    function automatic acc_t round_shift(acc_t v, int n);
        return (v + (acc_t'(1) <<< (n - 1))) >>> n;
    endfunction

    function automatic acc_t mul_px(logic [PIX_W-1:0] p, int k);
        return acc_t'({1'b0, p}) * acc_t'(k);
    endfunction

    function automatic acc_t mul_cs(comp_t a, int k);
        return acc_t'(a) * acc_t'(k);
    endfunction

    function automatic logic [PIX_W-1:0] clamp_pix(acc_t v);
        if (v < 0)
            return '0;
        else if (v > acc_t'(PIX_MAX))
            return '1;
        else
            return v[PIX_W-1:0];
    endfunction

    // Sine or cosine of k quarter-degrees in signed Q1.TRIG_F, by series in Q30.
    function automatic trig_t trig_q(int k, bit want_sin);
        longint pi_q30, x, x2, x3, x4, x5, x6, x7, v;
        pi_q30 = 64'sd3373259426;
        x  = (longint'(k) * pi_q30) / 720;
        x2 = (x * x) >>> 30;
        x3 = (x2 * x) >>> 30;
        x4 = (x2 * x2) >>> 30;
        x5 = (x4 * x) >>> 30;
        x6 = (x4 * x2) >>> 30;
        x7 = (x6 * x) >>> 30;
        if (want_sin)
            v = x - x3 / 6 + x5 / 120 - x7 / 5040;
        else
            v = (64'sd1 <<< 30) - x2 / 2 + x4 / 24 - x6 / 720;
        v = (v + (64'sd1 <<< (29 - TRIG_F))) >>> (30 - TRIG_F);
        return trig_t'(v);
    endfunction
endpackage

// File: rtl/vta_hue_rom.sv
module vta_hue_rom
    import vta_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [HUE_W-1:0] hue_i,
    output trig_t            sin_o,
    output trig_t            cos_o
);
    trig_t sin_tab [HUE_LIM+1];
    trig_t cos_tab [HUE_LIM+1];

    for (genvar k = 0; k <= HUE_LIM; k++) begin : g_tab
        localparam trig_t SIN_K = trig_q(k, 1'b1);
        localparam trig_t COS_K = trig_q(k, 1'b0);
        assign sin_tab[k] = SIN_K;
        assign cos_tab[k] = COS_K;
    end

    logic signed [HUE_W-1:0] code;
    logic [HUE_W-1:0]        mag;
    logic                    neg;

    always_comb begin
        code = $signed(hue_i);
        neg  = code < 0;
        if (code > HUE_W'(HUE_LIM) || code < -HUE_W'(HUE_LIM))
            mag = HUE_W'(HUE_LIM);
        else if (neg)
            mag = -code;
        else
            mag = code;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sin_o <= '0;
            cos_o <= '0;
        end else begin
            sin_o <= neg ? -sin_tab[mag] : sin_tab[mag];
            cos_o <= cos_tab[mag];
        end
    end

    AST_HUE_ZERO_IDENT: assert property (@(posedge clk) disable iff (rst)
        (hue_i == '0) |=> (sin_o == '0 && cos_o == trig_t'(1 << TRIG_F))); // R7
    AST_HUE_POS_LIMIT: assert property (@(posedge clk) disable iff (rst)
        ($signed(hue_i) > HUE_LIM) |=> (sin_o == sin_tab[HUE_LIM])); // R7
endmodule

// File: rtl/vta_csc_fwd.sv
module vta_csc_fwd
    import vta_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  rgb_t pix_i,
    output ycc_t ycc_o
);
    localparam int SH = COEF_F - FRAC_W;

    acc_t acc_y, acc_u, acc_v;

    always_comb begin
        acc_y = mul_px(pix_i.r, KF_YR) + mul_px(pix_i.g, KF_YG) + mul_px(pix_i.b, KF_YB);
        acc_u = mul_px(pix_i.r, KF_UR) + mul_px(pix_i.g, KF_UG) + mul_px(pix_i.b, KF_UB);
        acc_v = mul_px(pix_i.r, KF_VR) + mul_px(pix_i.g, KF_VG) + mul_px(pix_i.b, KF_VB);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ycc_o <= '0;
        end else begin
            ycc_o.y  <= comp_t'(round_shift(acc_y, SH));
            ycc_o.cb <= comp_t'(round_shift(acc_u, SH));
            ycc_o.cr <= comp_t'(round_shift(acc_v, SH));
        end
    end

    AST_GREY_NO_CHROMA: assert property (@(posedge clk) disable iff (rst)
        (pix_i.r == pix_i.g && pix_i.g == pix_i.b) |=> (ycc_o.cb == '0 && ycc_o.cr == '0)); // R4
endmodule

// File: rtl/vta_adjust.sv
module vta_adjust
    import vta_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ycc_t  ycc_i,
    input  ctl_t  ctl_i,
    input  trig_t sin_i,
    input  trig_t cos_i,
    output ycc_t  ycc_o
);
    // Stage A: contrast/brightness on luma, rotation on chroma.
    ycc_t              ycc_a;
    logic [GAIN_W-1:0] sat_a;
    acc_t              y_mul, u_rot, v_rot, bri_q;

    always_comb begin
        y_mul = acc_t'(ycc_i.y) * acc_t'({1'b0, ctl_i.contrast});
        bri_q = acc_t'($signed(ctl_i.bright)) <<< FRAC_W;
        u_rot = acc_t'(ycc_i.cb) * acc_t'(cos_i) + acc_t'(ycc_i.cr) * acc_t'(sin_i);
        v_rot = acc_t'(ycc_i.cr) * acc_t'(cos_i) - acc_t'(ycc_i.cb) * acc_t'(sin_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ycc_a <= '0;
            sat_a <= '0;
        end else begin
            ycc_a.y  <= comp_t'(round_shift(y_mul, GAIN_F) + bri_q);
            ycc_a.cb <= comp_t'(round_shift(u_rot, TRIG_F));
            ycc_a.cr <= comp_t'(round_shift(v_rot, TRIG_F));
            sat_a    <= ctl_i.sat;
        end
    end

    // Stage B: saturation gain on chroma.
    acc_t u_sat, v_sat;

    always_comb begin
        u_sat = acc_t'(ycc_a.cb) * acc_t'({1'b0, sat_a});
        v_sat = acc_t'(ycc_a.cr) * acc_t'({1'b0, sat_a});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ycc_o <= '0;
        end else begin
            ycc_o.y  <= ycc_a.y;
            ycc_o.cb <= comp_t'(round_shift(u_sat, GAIN_F));
            ycc_o.cr <= comp_t'(round_shift(v_sat, GAIN_F));
        end
    end

    AST_UNITY_LUMA: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.contrast == 8'd128 && ctl_i.bright == '0) |=> (ycc_a.y == $past(ycc_i.y))); // R3
    AST_SAT_ZERO_GREY: assert property (@(posedge clk) disable iff (rst)
        (sat_a == '0) |=> (ycc_o.cb == '0 && ycc_o.cr == '0)); // R8
endmodule

// File: rtl/vta_csc_inv.sv
module vta_csc_inv
    import vta_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ycc_t ycc_i,
    output rgb_t rgb_o
);
    localparam int SH = COEF_F + FRAC_W;

    acc_t acc_r, acc_g, acc_b;

    always_comb begin
        acc_r = mul_cs(ycc_i.y, KI_Y) + mul_cs(ycc_i.cr, KI_RV);
        acc_g = mul_cs(ycc_i.y, KI_Y) + mul_cs(ycc_i.cb, KI_GU) + mul_cs(ycc_i.cr, KI_GV);
        acc_b = mul_cs(ycc_i.y, KI_Y) + mul_cs(ycc_i.cb, KI_BU);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rgb_o <= '0;
        end else begin
            rgb_o.r <= clamp_pix(round_shift(acc_r, SH));
            rgb_o.g <= clamp_pix(round_shift(acc_g, SH));
            rgb_o.b <= clamp_pix(round_shift(acc_b, SH));
        end
    end

    AST_ZERO_CHROMA_GREY: assert property (@(posedge clk) disable iff (rst)
        (ycc_i.cb == '0 && ycc_i.cr == '0) |=> (rgb_o.r == rgb_o.g && rgb_o.g == rgb_o.b)); // R4
endmodule

// File: rtl/vid_tone_adjust.sv
module vid_tone_adjust
    import vta_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PIX_W-1:0]  in_r,
    input  logic [PIX_W-1:0]  in_g,
    input  logic [PIX_W-1:0]  in_b,
    input  logic              in_vs,
    input  logic              in_hs,
    input  logic              in_de,
    input  logic [GAIN_W-1:0] contrast,
    input  logic [BRI_W-1:0]  brightness,
    input  logic [HUE_W-1:0]  hue,
    input  logic [GAIN_W-1:0] saturation,
    output logic [PIX_W-1:0]  out_r,
    output logic [PIX_W-1:0]  out_g,
    output logic [PIX_W-1:0]  out_b,
    output logic              out_vs,
    output logic              out_hs,
    output logic              out_de
);
    rgb_t  pix_in, pix_out;
    ycc_t  ycc_f, ycc_j;
    ctl_t  ctl_f;
    trig_t sin_f, cos_f;

    assign pix_in = '{r: in_r, g: in_g, b: in_b};

    vta_csc_fwd u_fwd (.clk(clk), .rst(rst), .pix_i(pix_in), .ycc_o(ycc_f));

    vta_hue_rom u_rom (.clk(clk), .rst(rst), .hue_i(hue), .sin_o(sin_f), .cos_o(cos_f));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_f <= '0;
        end else begin
            ctl_f.contrast <= contrast;
            ctl_f.bright   <= brightness;
            ctl_f.sat      <= saturation;
        end
    end

    vta_adjust u_adj (.clk(clk), .rst(rst), .ycc_i(ycc_f), .ctl_i(ctl_f),
                      .sin_i(sin_f), .cos_i(cos_f), .ycc_o(ycc_j));

    vta_csc_inv u_inv (.clk(clk), .rst(rst), .ycc_i(ycc_j), .rgb_o(pix_out));

    // Marker delay chain matched to the pixel path.
    sync_t sync_in;
    sync_t sync_pipe [PIPE_LAT];

    assign sync_in = '{vs: in_vs, hs: in_hs, de: in_de};

    for (genvar i = 0; i < PIPE_LAT; i++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst)
                sync_pipe[i] <= '0;
            else if (i == 0)
                sync_pipe[i] <= sync_in;
            else
                sync_pipe[i] <= sync_pipe[(i == 0) ? 0 : i - 1];
        end
    end

    assign out_r  = pix_out.r;
    assign out_g  = pix_out.g;
    assign out_b  = pix_out.b;
    assign out_vs = sync_pipe[PIPE_LAT-1].vs;
    assign out_hs = sync_pipe[PIPE_LAT-1].hs;
    assign out_de = sync_pipe[PIPE_LAT-1].de;

    // Cycles since reset, saturating at the pipeline depth, for the alignment check.
    logic [2:0] warm_cnt;
    always_ff @(posedge clk) begin
        if (rst)
            warm_cnt <= '0;
        else if (warm_cnt != 3'd4)
            warm_cnt <= warm_cnt + 3'd1;
    end

    AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (warm_cnt == 3'd4) |-> ({out_vs, out_hs, out_de} == $past({in_vs, in_hs, in_de}, 4))); // R1
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> ({out_r, out_g, out_b, out_vs, out_hs, out_de} == '0)); // R2
endmodule

// File: tb/vid_tone_adjust_tb_top.sv
module vid_tone_adjust_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst;
    logic [7:0] in_r, in_g, in_b;
    logic       in_vs, in_hs, in_de;
    logic [7:0] contrast;
    logic [5:0] brightness;
    logic [7:0] hue, saturation;
    logic [7:0] out_r, out_g, out_b;
    logic       out_vs, out_hs, out_de;

    vid_tone_adjust dut_i (
        .clk(clk), .rst(rst), .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .in_vs(in_vs), .in_hs(in_hs), .in_de(in_de),
        .contrast(contrast), .brightness(brightness), .hue(hue), .saturation(saturation),
        .out_r(out_r), .out_g(out_g), .out_b(out_b),
        .out_vs(out_vs), .out_hs(out_hs), .out_de(out_de)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    int cyc      = 0;
    int unsigned seed = 32'h1234_5678;

    int       er [8];
    int       eg [8];
    int       eb [8];
    logic [2:0] es [8];
    int       etol [8];
    bit       ev [8];
    bit       egrey [8];
    string    ereq [8];

    function automatic int unsigned next_rand();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    function automatic int rnd(real x);
        if (x >= 0.0) return $rtoi(x + 0.5);
        return -$rtoi(0.5 - x);
    endfunction

    function automatic int clip(int v);
        if (v < 0) return 0;
        if (v > 255) return 255;
        return v;
    endfunction

    function automatic int absi(int v);
        return (v < 0) ? -v : v;
    endfunction

    // Real-valued model built from the requirement text (R5..R10).
    task automatic model(input int r, input int g, input int b, input int c, input int br,
                         input int h, input int s, output int orr, output int og, output int ob);
        real yp, cb, cr, y2, cb2, cr2, th, cs, sn;
        int  hc;
        hc = (h > 120) ? 120 : ((h < -120) ? -120 : h);
        th = hc * 0.25 * 3.14159265358979 / 180.0;
        cs = $cos(th);
        sn = $sin(th);
        yp = 0.2567890625 * r + 0.50412890625 * g + 0.09790625 * b;
        cb = -0.14822265625 * r - 0.2909921875 * g + 0.43921484375 * b;
        cr = 0.43921484375 * r - 0.3677890625 * g - 0.07142578125 * b;
        y2  = yp * c / 128.0 + br;
        cb2 = (cb * cs + cr * sn) * s / 128.0;
        cr2 = (cr * cs - cb * sn) * s / 128.0;
        orr = clip(rnd(1.1643828125 * y2 + 1.59602734375 * cr2));
        og  = clip(rnd(1.1643828125 * y2 - 0.39176171875 * cb2 - 0.81296875 * cr2));
        ob  = clip(rnd(1.1643828125 * y2 + 2.01723046875 * cb2));
    endtask

    task automatic check_slot();
        int k;
        k = cyc % 8;
        if (!ev[k]) return;
        n_checks++;
        if ({out_vs, out_hs, out_de} !== es[k]) begin
            n_fail++;
            $display("FAIL R1: markers %b expected %b", {out_vs, out_hs, out_de}, es[k]);
        end
        n_checks++;
        if (absi(int'(out_r) - er[k]) > etol[k] || absi(int'(out_g) - eg[k]) > etol[k] ||
            absi(int'(out_b) - eb[k]) > etol[k]) begin
            n_fail++;
            $display("FAIL %s: rgb=(%0d,%0d,%0d) expected (%0d,%0d,%0d) tol %0d",
                     ereq[k], out_r, out_g, out_b, er[k], eg[k], eb[k], etol[k]);
        end
        if (egrey[k]) begin
            n_checks++;
            if (out_r != out_g || out_g != out_b) begin
                n_fail++;
                $display("FAIL %s R4: rgb=(%0d,%0d,%0d) expected equal channels",
                         ereq[k], out_r, out_g, out_b);
            end
        end
    endtask

    // One pixel per cycle: check the output due now, then drive the next input.
    task automatic push(input int r, input int g, input int b, input int c, input int br,
                        input int h, input int s, input int tol, input string req,
                        input bit grey, input bit ident);
        int k, mr, mg, mb;
        logic [2:0] syn;
        @(negedge clk);
        check_slot();
        k = (cyc + 4) % 8;
        syn = 3'(next_rand());
        model(r, g, b, c, br, h, s, mr, mg, mb);
        if (ident) begin
            mr = r; mg = g; mb = b;
        end
        er[k] = mr; eg[k] = mg; eb[k] = mb;
        es[k] = syn; etol[k] = tol; ev[k] = 1'b1; egrey[k] = grey; ereq[k] = req;
        in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
        {in_vs, in_hs, in_de} = syn;
        contrast = 8'(c); brightness = 6'(br); hue = 8'(h); saturation = 8'(s);
        cyc++;
    endtask

    task automatic flush();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check_slot();
            ev[(cyc + 4) % 8] = 1'b0;
            cyc++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) ev[i] = 1'b0;
        rst = 1'b1;
        in_r = 8'd200; in_g = 8'd100; in_b = 8'd50;
        {in_vs, in_hs, in_de} = 3'b111;
        contrast = 8'd255; brightness = 6'd31; hue = 8'd40; saturation = 8'd200;
        repeat (6) @(negedge clk);
        // R2: outputs held at zero under reset despite active inputs
        n_checks++;
        if ({out_r, out_g, out_b, out_vs, out_hs, out_de} !== '0) begin
            n_fail++;
            $display("FAIL R2: outputs %h expected 0", {out_r, out_g, out_b, out_vs, out_hs, out_de});
        end
        rst = 1'b0;

        // R3: neutral controls over a 16-step RGB grid
        for (int r = 0; r < 256; r += 17)
            for (int g = 0; g < 256; g += 17)
                for (int b = 0; b < 256; b += 17)
                    push(r, g, b, 128, 0, 0, 128, 1, "R3", 1'b0, 1'b1);

        // R4: every grey level with varied controls
        for (int v = 0; v < 256; v++)
            push(v, v, v, int'(next_rand() % 256), int'(next_rand() % 64) - 32,
                 int'(next_rand() % 256) - 128, int'(next_rand() % 256), 2, "R4", 1'b1, 1'b0);

        // R5: contrast sweep
        for (int c = 0; c < 256; c++)
            push(180, 90, 40, c, 0, 0, 128, 2, "R5", 1'b0, 1'b0);

        // R6: brightness sweep
        for (int br = -32; br < 32; br++) begin
            push(120, 60, 200, 128, br, 0, 128, 2, "R6", 1'b0, 1'b0);
            push(10, 10, 10, 128, br, 0, 128, 2, "R6", 1'b1, 1'b0);
        end

        // R7: every hue code, including codes past the +/-120 limit
        for (int h = -128; h < 128; h++)
            push(200, 40, 90, 128, 0, h, 128, 2, "R7", 1'b0, 1'b0);

        // R8: saturation sweep; code 0 must give grey
        for (int s = 0; s < 256; s++)
            push(30, 170, 220, 128, 0, 16, s, 2, "R8", s == 0, 1'b0);

        // R9: clamp at both ends
        push(0, 0, 0, 0, -32, 0, 128, 0, "R9", 1'b1, 1'b0);
        push(20, 20, 20, 128, -32, 0, 128, 0, "R9", 1'b1, 1'b0);
        push(255, 255, 255, 255, 31, 0, 128, 0, "R9", 1'b1, 1'b0);
        push(255, 0, 0, 255, 31, 0, 255, 2, "R9", 1'b0, 1'b0);
        push(0, 0, 255, 128, 0, 120, 255, 2, "R9", 1'b0, 1'b0);
        push(0, 255, 0, 200, -20, -120, 255, 2, "R9", 1'b0, 1'b0);

        // R10 R11: random pixels with controls changing on every pixel
        for (int i = 0; i < 20000; i++)
            push(int'(next_rand() % 256), int'(next_rand() % 256), int'(next_rand() % 256),
                 int'(next_rand() % 256), int'(next_rand() % 64) - 32,
                 int'(next_rand() % 256) - 128, int'(next_rand() % 256),
                 2, "R10 R11", 1'b0, 1'b0);

        flush();
        finish_run();
    end
endmodule